// File: doc/BRIEF.md
# Output Fault Latch and Bus Switch Controller

This block supervises the fault comparators of a secondary-side power adapter output and drives two open-drain style controls: an over-voltage shutdown line that pulls an optocoupler low to stop the primary converter, and an active-low enable for the blocking switch that connects the converter to the bus. Every fault input is first brought into the clock domain by a two-flop synchroniser and then qualified by a consecutive-sample debounce counter. Any deasserted sample restarts that counter.

A qualified over-voltage fault sets a latch. The shutdown line stays asserted until the supply-collapse flag reports that the local supply has dropped below its turn-off level, and no register write can release it. The bus switch is turned on only while a sink is attached, either after contract negotiation or while a pull-down is seen on a configuration line. It is forced off by any qualified fault. Sticky status bits record each fault for firmware and are cleared by write-one-to-clear. The over-voltage threshold select is handed through to the analog comparator, with the one unused code mapped to a legal one.

Top module: `vbus_fault_guard`

## Requirements
- R1: `ovp_sel_o` equals `ovp_sel_i` for codes 00, 01 and 10, which select 120 %, 125 % and 130 % of the voltage reference. Code 11 is driven out as 10.
- R2: An over-voltage comparator pulse held for fewer than `OV_DEB` clock cycles has no effect. A pulse broken by one low cycle restarts the count and also has no effect.
- R3: Once taken, the over-voltage latch holds `shutdown_n_o` low after the comparator drops and after a write-one-to-clear of its status bit. It releases three clock edges after `vdd_off_i` rises.
- R4: `vbus_en_n_o` is low only when `sink_negotiated_i` or `cc_rd_seen_i` is high and no fault is active. With neither attach input high it is 1.
- R5: A qualified under-voltage, over-temperature or short-circuit fault forces `vbus_en_n_o` to 1 while it lasts. A latched over-voltage fault forces it to 1 until the latch releases.
- R6: The over-temperature comparator must stay high for `ot_deglitch_i` consecutive cycles before it qualifies. A value of 0 behaves as 1.
- R7: The under-voltage and short-circuit inputs qualify after `UV_DEB` and `SC_DEB` consecutive high cycles respectively.
- R8: `fault_status_o` bits are sticky, with index 0 for over-voltage, 1 for under-voltage, 2 for over-temperature and 3 for short-circuit. A 1 in the matching bit of `status_clr_i` clears a bit, but a still-qualified fault wins in the same cycle.
- R9: During and right after reset, `shutdown_n_o` is 1, `vbus_en_n_o` is 1 and `fault_status_o` is 0.
- R10: When `ovp_cmp_i` rises just before clock edge 1 and stays high, `shutdown_n_o`, `vbus_en_n_o` and status bit 0 change at edge `OV_DEB`+3 and not before.
- R11: While `vdd_off_i` is high, a qualified over-voltage fault does not assert `shutdown_n_o`, but it still sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovp_cmp_i | input | 1 | Output over-voltage comparator, high means over |
| ovp_sel_i | input | 2 | Over-voltage threshold select from configuration |
| ovp_sel_o | output | 2 | Threshold select handed to the comparator |
| vdd_off_i | input | 1 | Supply below its turn-off level |
| sink_negotiated_i | input | 1 | Sink attached after contract negotiation |
| cc_rd_seen_i | input | 1 | Pull-down detected on a configuration line |
| uv_cmp_i | input | 1 | Output under-voltage comparator |
| sc_cmp_i | input | 1 | Output short-circuit comparator |
| ot_cmp_i | input | 1 | Thermistor node below its over-temperature threshold |
| ot_deglitch_i | input | OT_W | Over-temperature deglitch length in cycles |
| status_clr_i | input | 4 | Write-one-to-clear strobe for the status bits |
| shutdown_n_o | output | 1 | Shutdown line, 0 means pull low |
| vbus_en_n_o | output | 1 | Bus switch enable, active low |
| fault_status_o | output | 4 | Sticky fault status bits |

## Verification
Two events can land on the same clock edge: a write-one-to-clear of a status bit and a fault that is still qualified and sets that bit again. The bench holds the under-voltage input high until it qualifies, pulses the clear strobe for one cycle, and requires the bit to read 1 afterwards. Once the input is released, the same strobe must read back 0. A second overlap is the supply-collapse flag and a qualifying over-voltage fault. The bench holds both high and checks that the shutdown line stays released while the status bit and the switch still react.

// File: rtl/fg_pkg.sv
// Package: shared fault indices and the threshold-select mapping.
// Assumes four supervised faults in a fixed order that the status bits expose.
package fg_pkg;
    localparam int NFLT   = 4;
    localparam int F_OV   = 0;
    localparam int F_UV   = 1;
    localparam int F_OT   = 2;
    localparam int F_SC   = 3;

    // Map the unused threshold code onto the highest legal threshold.
    function automatic logic [1:0] legal_sel(input logic [1:0] code);
        return (code == 2'b11) ? 2'b10 : code;
    endfunction
endpackage

// File: rtl/fg_sync2.sv
// fg_sync2: two-flop synchroniser for W independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherence is provided.
module fg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/fg_debounce.sv
// fg_debounce: synchronises one fault input and qualifies it after lim_i
// consecutive high samples (0 treated as 1). Any low sample restarts.
// Assumes lim_i is quasi-static while a fault is being counted.
module fg_debounce #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic [CW-1:0] lim_i,
    output logic          qual_o
);
    logic          smp;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;

    fg_sync2 #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_i),
        .q_o   (smp)
    );

    // Terminal count, with a zero limit behaving as one.
    always_comb lim_m1 = (lim_i == '0) ? '0 : lim_i - 1'b1;

    // Count consecutive high samples; restart on any low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            qual_o <= 1'b0;
        end else if (!smp) begin
            cnt    <= '0;
            qual_o <= 1'b0;
        end else if (!qual_o) begin
            if (cnt == lim_m1) qual_o <= 1'b1;
            else               cnt    <= cnt + 1'b1;
        end
    end

    AST_DEB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !smp |=> (cnt == '0) && !qual_o);                                    // R2
    AST_DEB_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_o) |-> ($past(cnt) == $past(lim_m1)) && $past(smp));      // R6
endmodule

// File: rtl/fg_ovp_latch.sv
// fg_ovp_latch: holds the over-voltage shutdown once a qualified fault is
// seen; only the synchronised supply-collapse flag releases it, and that
// flag also blocks setting.
module fg_ovp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_qual_i,
    input  logic supply_off_i,
    output logic latched_o
);
    // Supply collapse has priority over a new set.
    always_ff @(posedge clk) begin
        if (!rst_n)            latched_o <= 1'b0;
        else if (supply_off_i) latched_o <= 1'b0;
        else if (ov_qual_i)    latched_o <= 1'b1;
    end

    AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        latched_o && !supply_off_i |=> latched_o);                           // R3
    AST_OVP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ov_qual_i && !supply_off_i |=> latched_o);                           // R10
    AST_OVP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        supply_off_i |=> !latched_o);                                        // R11
endmodule

// File: rtl/fg_switch_status.sv
// fg_switch_status: registers the active-low bus switch enable from attach
// state and faults, and keeps sticky write-one-to-clear status bits.
// Assumes clr_i is a single-cycle strobe in this clock domain.
module fg_switch_status
    import fg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            attached_i,
    input  logic            ov_latched_i,
    input  logic [NFLT-1:0] fault_q_i,
    input  logic [NFLT-1:0] clr_i,
    output logic            en_n_o,
    output logic [NFLT-1:0] status_o
);
    logic any_fault;

    // Any qualified fault or a held over-voltage latch blocks the switch.
    always_comb any_fault = (|fault_q_i) | ov_latched_i;

    // Switch enable: on only for an attached sink with no fault.
    always_ff @(posedge clk) begin
        if (!rst_n) en_n_o <= 1'b1;
        else        en_n_o <= !(attached_i && !any_fault);
    end

    // Sticky status: a live fault wins over a clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | fault_q_i;
    end

    AST_EN_OFF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |=> en_n_o);                                               // R5
    AST_EN_OFF_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        !attached_i |=> en_n_o);                                             // R4
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        |fault_q_i |=> ((status_o & $past(fault_q_i)) == $past(fault_q_i))); // R8
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i == '0 |=> ((status_o & $past(status_o)) == $past(status_o)));  // R8
endmodule

// File: rtl/vbus_fault_guard.sv
// vbus_fault_guard: top of the output fault supervisor. Debounces four
// fault comparators, latches over-voltage shutdown until supply collapse,
// drives the bus switch enable and exposes sticky status.
// Assumes all comparator and attach inputs are asynchronous levels.
module vbus_fault_guard
    import fg_pkg::*;
#(
    parameter int OV_DEB = 1080,
    parameter int UV_DEB = 216,
    parameter int SC_DEB = 22,
    parameter int OT_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovp_cmp_i,
    input  logic [1:0]      ovp_sel_i,
    output logic [1:0]      ovp_sel_o,
    input  logic            vdd_off_i,
    input  logic            sink_negotiated_i,
    input  logic            cc_rd_seen_i,
    input  logic            uv_cmp_i,
    input  logic            sc_cmp_i,
    input  logic            ot_cmp_i,
    input  logic [OT_W-1:0] ot_deglitch_i,
    input  logic [3:0]      status_clr_i,
    output logic            shutdown_n_o,
    output logic            vbus_en_n_o,
    output logic [3:0]      fault_status_o
);
    localparam int MAXFIX = (OV_DEB > UV_DEB) ? ((OV_DEB > SC_DEB) ? OV_DEB : SC_DEB)
                                              : ((UV_DEB > SC_DEB) ? UV_DEB : SC_DEB);
    localparam int CWFIX  = $clog2(MAXFIX + 1);
    localparam int CW     = (CWFIX > OT_W) ? CWFIX : OT_W;

    logic [NFLT-1:0] raw;
    logic [NFLT-1:0] qual;
    logic [CW-1:0]   lim [NFLT];
    logic [2:0]      ctl_s;
    logic            ov_latched;
    logic            attached;

    // Gather comparators and limits in fault-index order.
    always_comb begin
        raw          = '0;
        raw[F_OV]    = ovp_cmp_i;
        raw[F_UV]    = uv_cmp_i;
        raw[F_OT]    = ot_cmp_i;
        raw[F_SC]    = sc_cmp_i;
        lim[F_OV]    = CW'(OV_DEB);
        lim[F_UV]    = CW'(UV_DEB);
        lim[F_OT]    = CW'(ot_deglitch_i);
        lim[F_SC]    = CW'(SC_DEB);
    end

    for (genvar i = 0; i < NFLT; i++) begin : g_deb
        fg_debounce #(.CW(CW)) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[i]),
            .lim_i  (lim[i]),
            .qual_o (qual[i])
        );
    end

    fg_sync2 #(.W(3)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({vdd_off_i, cc_rd_seen_i, sink_negotiated_i}),
        .q_o   (ctl_s)
    );

    // Either attach indication counts as an attached sink.
    always_comb attached = ctl_s[0] | ctl_s[1];

    fg_ovp_latch u_ovl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ov_qual_i    (qual[F_OV]),
        .supply_off_i (ctl_s[2]),
        .latched_o    (ov_latched)
    );

    fg_switch_status u_sw (
        .clk          (clk),
        .rst_n        (rst_n),
        .attached_i   (attached),
        .ov_latched_i (ov_latched),
        .fault_q_i    (qual),
        .clr_i        (status_clr_i),
        .en_n_o       (vbus_en_n_o),
        .status_o     (fault_status_o)
    );

    // Outputs: open-drain style shutdown and legalised threshold select.
    always_comb shutdown_n_o = !ov_latched;
    always_comb ovp_sel_o    = legal_sel(ovp_sel_i);

    AST_SHDN_ONLY_OV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_n_o) |-> fault_status_o[F_OV]);                       // R3
    AST_SEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_sel_i != 2'b11 |-> ovp_sel_o == ovp_sel_i);                      // R1
endmodule

// File: tb/tb_vbus_fault_guard.sv
module tb_vbus_fault_guard;
    localparam int CLK_PERIOD = 10;
    localparam int OV_N = 8;
    localparam int UV_N = 5;
    localparam int SC_N = 3;
    localparam int OTW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovp_cmp = 0, vdd_off = 0, neg = 0, ccrd = 0, uv = 0, sc = 0, ot = 0;
    logic [1:0] sel_i = 0;
    logic [1:0] sel_o;
    logic [OTW-1:0] otdg = 0;
    logic [3:0] clr = 0;
    logic shdn_n, en_n;
    logic [3:0] st;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbus_fault_guard #(.OV_DEB(OV_N), .UV_DEB(UV_N), .SC_DEB(SC_N), .OT_W(OTW)) dut (
        .clk(clk), .rst_n(rst_n), .ovp_cmp_i(ovp_cmp), .ovp_sel_i(sel_i),
        .ovp_sel_o(sel_o), .vdd_off_i(vdd_off), .sink_negotiated_i(neg),
        .cc_rd_seen_i(ccrd), .uv_cmp_i(uv), .sc_cmp_i(sc), .ot_cmp_i(ot),
        .ot_deglitch_i(otdg), .status_clr_i(clr), .shutdown_n_o(shdn_n),
        .vbus_en_n_o(en_n), .fault_status_o(st));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        clr = 4'hF; tick(1); clr = 4'h0; tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        chk("R9 shutdown in reset", shdn_n, 1);
        chk("R9 enable in reset", en_n, 1);
        chk("R9 status in reset", st, 0);
        rst_n = 1'b1; tick(1);
        chk("R9 status after reset", {shdn_n, en_n, st}, 6'b110000);

        // R1: every select code
        for (int s = 0; s < 4; s++) begin
            sel_i = 2'(s); #1;
            chk("R1 select", sel_o, (s == 3) ? 2 : s);
        end

        // R4: attach combinations with no fault
        for (int a = 0; a < 4; a++) begin
            neg = a[0]; ccrd = a[1]; tick(4);
            chk("R4 attach", en_n, (a != 0) ? 0 : 1);
        end
        neg = 1; ccrd = 0; tick(4);

        // R2: short pulse ignored, broken pulse restarts
        ovp_cmp = 1; tick(OV_N - 1); ovp_cmp = 0; tick(6);
        chk("R2 short pulse", {shdn_n, st[0]}, 2'b10);
        ovp_cmp = 1; tick(OV_N - 2); ovp_cmp = 0; tick(1);
        ovp_cmp = 1; tick(OV_N - 2); ovp_cmp = 0; tick(6);
        chk("R2 broken pulse", {shdn_n, en_n, st[0]}, 3'b100);

        // R10: exact latency of the over-voltage path
        ovp_cmp = 1; tick(OV_N + 2);
        chk("R10 before edge", {shdn_n, en_n, st[0]}, 3'b100);
        tick(1);
        chk("R10 at edge", {shdn_n, en_n, st[0]}, 3'b011);

        // R3: latch holds through comparator drop and status clear
        ovp_cmp = 0; tick(10);
        chk("R3 hold after drop", {shdn_n, en_n}, 2'b01);
        clr = 4'b0001; tick(1); clr = 0; tick(1);
        chk("R3 hold after w1c", {shdn_n, st[0]}, 2'b00);
        vdd_off = 1; tick(2);
        chk("R3 not yet released", shdn_n, 0);
        tick(1);
        chk("R3 released", shdn_n, 1);

        // R11: supply collapse blocks the latch but not status or switch
        ovp_cmp = 1; tick(OV_N + 5);
        chk("R11 blocked", {shdn_n, en_n, st[0]}, 3'b111);
        ovp_cmp = 0; tick(4); vdd_off = 0; tick(4); clear_all();
        chk("R4 recovered", {shdn_n, en_n, st}, 6'b100000);

        // R7/R5: under-voltage and short-circuit, non-latched
        uv = 1; tick(UV_N - 1); uv = 0; tick(5);
        chk("R7 uv short", {en_n, st[1]}, 2'b00);
        uv = 1; tick(UV_N + 4);
        chk("R5 uv forces off", {en_n, st[1]}, 2'b11);
        // R8: clear while the fault is still qualified
        clr = 4'b0010; tick(1); clr = 0; tick(1);
        chk("R8 set wins over clear", st[1], 1);
        uv = 0; tick(5);
        chk("R5 uv recovers", en_n, 0);
        clr = 4'b0010; tick(1); clr = 0; tick(1);
        chk("R8 clear", st, 0);
        sc = 1; tick(SC_N - 1); sc = 0; tick(5);
        chk("R7 sc short", {en_n, st[3]}, 2'b00);
        sc = 1; tick(SC_N + 4);
        chk("R5 sc forces off", {en_n, st[3]}, 2'b11);
        sc = 0; tick(5); clear_all();
        chk("R5 sc recovers", {en_n, st}, 5'b00000);

        // R6: over-temperature deglitch sweep
        for (int l = 0; l < 7; l++) begin
            int eff;
            eff = (l == 0) ? 1 : l;
            otdg = OTW'(l);
            if (eff > 1) begin
                ot = 1; tick(eff - 1); ot = 0; tick(5);
                chk("R6 ot below limit", st[2], 0);
            end
            ot = 1; tick(eff); ot = 0; tick(5);
            chk("R6 ot at limit", st[2], 1);
            clear_all();
        end
        ot = 1; otdg = 3; tick(8);
        chk("R5 ot forces off", en_n, 1);
        ot = 0; tick(5);
        chk("R5 ot recovers", en_n, 0);

        neg = 0; tick(4);
        chk("R4 detach", en_n, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule